// File: doc/BRIEF.md
# Boundary-Scan Data Chain with Update Latches

This block is the pin-side data register of a test access port. Every input pin has a capture/shift stage. Every output pin has a pair of cells: an enable cell and a data cell. Each cell of that pair has a capture/shift stage and an update stage. The TAP controller supplies three things: one-cycle state strobes for capture, shift and update; a chain-select line; and the decoded test-mode lines. The block needs no other control.

In functional mode the core's output values and output enables pass straight to the pins. Capturing and shifting run in the background without touching the pins. A serial pattern can therefore be shifted in and moved into the update stages while the system keeps running. That preload is then driven onto the pins once an external-test or clamp mode is selected. A high-impedance mode turns every pin driver off.

Top module: `bsr_chain`

## Requirements
- R1: While `tlr` is high at a clock edge, every shift stage (rising edge) and every update stage (falling edge) is cleared to 0. Right after reset, any drive mode therefore presents 0 on every `pin_out` and `pin_oe`.
- R2: On a rising edge with `sel` and `capture_dr` high, the chain loads a snapshot. Shift stage i takes `pin_in[i]` for i < N_IN. For pin j, stage N_IN+2j takes `core_oe[j]` and stage N_IN+2j+1 takes `core_out[j]`.
- R3: On a rising edge with `sel` and `shift_dr` high, stage i takes stage i+1, the last stage takes `tdi`, and stage 0 is the bit shown on `tdo`.
- R4: With `sel` low, the shift stages keep their contents whatever the strobes and `tdi` do, and `tdo` is 0.
- R5: With no test mode active, `pin_out` equals `core_out` and `pin_oe` equals `core_oe` in every cycle, including cycles of capture, shift and update.
- R6: On a falling edge with `sel` and `update_dr` high, each update stage copies its shift stage. At every other falling edge the update stages hold.
- R7: With `mode_extest` or `mode_clamp` high and `mode_highz` low, `pin_oe[j]` is the update stage at N_IN+2j and `pin_out[j]` is the update stage at N_IN+2j+1. The core values have no effect.
- R8: With `mode_highz` high, every `pin_oe` and `pin_out` is 0, whatever the other modes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture and shift on the rise, update on the fall |
| tlr | input | 1 | Test-logic-reset state, synchronous clear |
| sel | input | 1 | This chain is the selected data register |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| mode_extest | input | 1 | External-test mode active |
| mode_clamp | input | 1 | Clamp mode active |
| mode_highz | input | 1 | High-impedance mode active |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| pin_in | input | N_IN | Input pin values |
| core_out | input | N_IO | Core output data |
| core_oe | input | N_IO | Core output enables |
| pin_out | output | N_IO | Data to the pin drivers |
| pin_oe | output | N_IO | Enable of the pin drivers |

## Verification
A stage that captures or shifts wrongly shows up on `tdo`. The error appears at the first rising edge where that stage reaches position 0, so at most one chain length of shift cycles after the error. An update stage that loads at the wrong moment, or that misses a load, stays hidden in functional mode. It shows up on `pin_out` or `pin_oe` in the first cycle a drive mode is selected. For that reason the bench compares `tdo` and every pin on every clock against a queue-based model, and it enters drive modes both right after preloads and after long stretches of shifting without an update.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        PM_FUNC  = 2'd0,
        PM_DRIVE = 2'd1,
        PM_FLOAT = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic dat;
    } pin_drive_t;

    function automatic pin_mode_e pick_mode(input logic extest,
                                            input logic clamp,
                                            input logic highz);
        if (highz)
            return PM_FLOAT;
        else if (extest || clamp)
            return PM_DRIVE;
        else
            return PM_FUNC;
    endfunction

    function automatic int unsigned en_slot(input int unsigned n_in,
                                            input int unsigned j);
        return n_in + 2 * j;
    endfunction

    function automatic int unsigned dat_slot(input int unsigned n_in,
                                             input int unsigned j);
        return n_in + 2 * j + 1;
    endfunction

endpackage

// File: rtl/bsr_shift.sv
module bsr_shift #(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           tlr,
    input  logic           sel,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] stages
);

    always_ff @(posedge tck) begin
        if (tlr)
            stages <= '0;
        else if (sel && capture_dr)
            stages <= cap_vec;
        else if (sel && shift_dr)
            stages <= {tdi, stages[LEN-1:1]};
    end

    AST_CAPTURE_SNAP: assert property (@(posedge tck) disable iff (tlr)
        (sel && capture_dr) |=> (stages == $past(cap_vec)));          // R2
    AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (tlr)
        (sel && shift_dr && !capture_dr) |=> (stages[LEN-1] == $past(tdi))); // R3
    AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (tlr)
        (sel && shift_dr && !capture_dr) |=> (stages[LEN-2:0] == $past(stages[LEN-1:1]))); // R3
    AST_UNSEL_HOLD: assert property (@(posedge tck) disable iff (tlr)
        !sel |=> $stable(stages));                                    // R4

endmodule

// File: rtl/bsr_update.sv
module bsr_update #(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           tlr,
    input  logic           sel,
    input  logic           update_dr,
    input  logic [LEN-1:0] stages,
    output logic [LEN-1:0] held
);

    always_ff @(negedge tck) begin
        if (tlr)
            held <= '0;
        else if (sel && update_dr)
            held <= stages;
    end

    AST_UPD_CLEAR: assert property (@(negedge tck)
        tlr |=> (held == '0));                                        // R1
    AST_UPD_HOLD: assert property (@(negedge tck) disable iff (tlr)
        !(sel && update_dr) |=> $stable(held));                       // R6
    AST_UPD_LOAD: assert property (@(negedge tck) disable iff (tlr)
        (sel && update_dr) |=> (held == $past(stages)));              // R6

endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
    import bsr_pkg::*;
#(
    parameter int N_IO = 2
) (
    input  pin_mode_e       mode,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    input  pin_drive_t      held_drv [N_IO],
    output logic [N_IO-1:0] pin_out,
    output logic [N_IO-1:0] pin_oe
);

    for (genvar j = 0; j < N_IO; j++) begin : g_pin
        always_comb begin
            unique case (mode)
                PM_DRIVE: begin
                    pin_out[j] = held_drv[j].dat;
                    pin_oe[j]  = held_drv[j].oe;
                end
                PM_FLOAT: begin
                    pin_out[j] = 1'b0;
                    pin_oe[j]  = 1'b0;
                end
                default: begin
                    pin_out[j] = core_out[j];
                    pin_oe[j]  = core_oe[j];
                end
            endcase
        end
    end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int N_IO = 3
) (
    input  logic            tck,
    input  logic            tlr,
    input  logic            sel,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            mode_extest,
    input  logic            mode_clamp,
    input  logic            mode_highz,
    input  logic            tdi,
    output logic            tdo,
    input  logic [N_IN-1:0] pin_in,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic [N_IO-1:0] pin_out,
    output logic [N_IO-1:0] pin_oe
);

    localparam int LEN = N_IN + 2 * N_IO;

    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] stages;
    logic [LEN-1:0] held;
    pin_drive_t     held_drv [N_IO];
    pin_mode_e      mode;

    assign cap_vec[N_IN-1:0] = pin_in;

    for (genvar j = 0; j < N_IO; j++) begin : g_cell
        localparam int EN_I  = en_slot(N_IN, j);
        localparam int DAT_I = dat_slot(N_IN, j);
        assign cap_vec[EN_I]   = core_oe[j];
        assign cap_vec[DAT_I]  = core_out[j];
        assign held_drv[j].oe  = held[EN_I];
        assign held_drv[j].dat = held[DAT_I];
    end

    assign mode = pick_mode(mode_extest, mode_clamp, mode_highz);

    bsr_shift #(.LEN(LEN)) u_shift (
        .tck        (tck),
        .tlr        (tlr),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .stages     (stages)
    );

    bsr_update #(.LEN(LEN)) u_update (
        .tck       (tck),
        .tlr       (tlr),
        .sel       (sel),
        .update_dr (update_dr),
        .stages    (stages),
        .held      (held)
    );

    bsr_pin_mux #(.N_IO(N_IO)) u_mux (
        .mode     (mode),
        .core_out (core_out),
        .core_oe  (core_oe),
        .held_drv (held_drv),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    assign tdo = sel ? stages[0] : 1'b0;

    AST_FUNC_PASS: assert property (@(posedge tck) disable iff (tlr)
        (!mode_extest && !mode_clamp && !mode_highz)
        |-> (pin_out == core_out && pin_oe == core_oe));             // R5
    AST_FLOAT_OFF: assert property (@(posedge tck) disable iff (tlr)
        mode_highz |-> (pin_oe == '0 && pin_out == '0));              // R8
    AST_UNSEL_TDO: assert property (@(posedge tck) disable iff (tlr)
        !sel |-> !tdo);                                               // R4

endmodule

// File: tb/sim_bsr_chain.sv
`timescale 1ns/100ps
module sim_bsr_chain;

    localparam int N_IN = 4;
    localparam int N_IO = 3;
    localparam int LEN  = N_IN + 2 * N_IO;

    logic tck = 1'b0;
    logic tlr = 1'b1;
    logic sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic mode_extest = 1'b0, mode_clamp = 1'b0, mode_highz = 1'b0;
    logic tdi = 1'b0;
    logic tdo;
    logic [N_IN-1:0] pin_in = '0;
    logic [N_IO-1:0] core_out = '0, core_oe = '0;
    logic [N_IO-1:0] pin_out, pin_oe;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;
    string phase = "R1";

    logic mq[$];
    logic mu[LEN];

    always #2 tck = ~tck;

    bsr_chain #(.N_IN(N_IN), .N_IO(N_IO)) u0 (
        .tck(tck), .tlr(tlr), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr),
        .mode_extest(mode_extest), .mode_clamp(mode_clamp),
        .mode_highz(mode_highz), .tdi(tdi), .tdo(tdo), .pin_in(pin_in),
        .core_out(core_out), .core_oe(core_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // capture value per slot, from the layout in R2
    function automatic logic cap_bit(input int i);
        if (i < N_IN) return pin_in[i];
        if (((i - N_IN) % 2) == 0) return core_oe[(i - N_IN) / 2];
        return core_out[(i - N_IN) / 2];
    endfunction

    always @(posedge tck) begin
        if (tlr) begin
            mq.delete();
            for (int i = 0; i < LEN; i++) mq.push_back(1'b0);
        end else if (sel && capture_dr) begin
            mq.delete();
            for (int i = 0; i < LEN; i++) mq.push_back(cap_bit(i));
        end else if (sel && shift_dr) begin
            void'(mq.pop_front());
            mq.push_back(tdi);
        end
    end

    always @(negedge tck) begin
        if (tlr) begin
            for (int i = 0; i < LEN; i++) mu[i] = 1'b0;
        end else if (sel && update_dr) begin
            for (int i = 0; i < LEN; i++) mu[i] = mq[i];
        end
    end

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge tck) begin
        #1;
        if (started && !done) begin
            string mtag;
            logic eo, ee;
            check_bit(sel ? phase : "R4", "tdo", tdo, sel ? mq[0] : 1'b0);
            mtag = mode_highz ? "R8" : ((mode_extest || mode_clamp) ? "R7" : "R5");
            if (phase == "R1" || phase == "R6") mtag = phase;
            for (int j = 0; j < N_IO; j++) begin
                if (mode_highz) begin
                    eo = 1'b0; ee = 1'b0;
                end else if (mode_extest || mode_clamp) begin
                    eo = mu[N_IN + 2*j + 1]; ee = mu[N_IN + 2*j];
                end else begin
                    eo = core_out[j]; ee = core_oe[j];
                end
                check_bit(mtag, $sformatf("pin_out[%0d]", j), pin_out[j], eo);
                check_bit(mtag, $sformatf("pin_oe[%0d]", j), pin_oe[j], ee);
            end
        end
    end

    task automatic tick();
        @(posedge tck);
        #1.5;
    endtask

    task automatic strobes(input logic c, input logic s, input logic u);
        capture_dr = c; shift_dr = s; update_dr = u;
    endtask

    task automatic modes(input logic e, input logic c, input logic h);
        mode_extest = e; mode_clamp = c; mode_highz = h;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge tck);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        tlr = 1'b1;
        repeat (3) tick();
        tlr = 1'b0;
        started = 1;

        // R1: drive modes right after reset show cleared update stages
        phase = "R1";
        modes(1, 0, 0); core_out = '1; core_oe = '1;
        tick(); tick();
        modes(0, 1, 0); tick();
        modes(0, 0, 0);

        // R2/R5: capture in functional mode, pins untouched
        phase = "R2";
        sel = 1; pin_in = 4'b1011; core_out = 3'b101; core_oe = 3'b011;
        strobes(1, 0, 0); tick();
        // R3: shift out the snapshot, feed an alternating pattern
        phase = "R3";
        strobes(0, 1, 0);
        for (int k = 0; k < LEN + 2; k++) begin
            tdi = k[0]; core_out = k[2:0]; tick();
        end

        // R4: deselected chain holds under strobes
        phase = "R4";
        sel = 0;
        for (int k = 0; k < 6; k++) begin
            tdi = ~tdi; strobes(k[0], 1, k[1]); tick();
        end
        strobes(0, 0, 0); sel = 1; tick();

        // R6: preload a pattern, update once, keep shifting with no update
        phase = "R6";
        strobes(0, 1, 0);
        for (int k = 0; k < LEN; k++) begin
            tdi = (k % 3 == 0); tick();
        end
        strobes(0, 0, 1); tick();
        strobes(0, 1, 0);
        for (int k = 0; k < 5; k++) begin
            tdi = 1'b1; tick();
        end
        strobes(0, 0, 0);
        modes(1, 0, 0); tick(); tick();

        // R7: drive modes ignore core values
        phase = "R7";
        for (int k = 0; k < 8; k++) begin
            core_out = k[2:0]; core_oe = ~k[2:0];
            modes(k[0], ~k[0], 0); tick();
        end

        // R8: high impedance wins over drive modes
        phase = "R8";
        modes(1, 1, 1); tick();
        modes(0, 0, 1); core_oe = '1; tick();
        modes(0, 0, 0); tick();

        // mixed traffic; one strobe at a time as a TAP would give
        phase = "R3";
        for (int k = 0; k < 400; k++) begin
            int unsigned r;
            r = $urandom;
            sel = (r[3:0] != 0);
            strobes(r[5:4] == 1, r[5:4] == 2, r[5:4] == 3);
            modes(r[6], r[7], r[9:8] == 0);
            tdi = r[10];
            pin_in = r[14:11];
            core_out = r[17:15];
            core_oe = r[20:18];
            tlr = (r[30:24] == 0);
            tick();
        end
        tlr = 0;
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule